// File: doc/BRIEF.md
# Data-Side Address Translation with Fault Capture

This block turns the virtual address of a load or store into a physical address. In front of it sits a set of access-control inputs: the core's current privilege mode, an alternate mode, a privileged-code flag, and a superpage enable field. Behind it sits an external translation table. The table receives the virtual page number and address-space number from this block on combinational outputs, and it answers in the same cycle with hit, frame number, per-mode read and write enables, and fault-on-read / fault-on-write bits. The block registers its result one cycle after the request: a physical address, a fault code and an uncached indication.

When a request faults, the block can record three things: the faulting address, a packed status word (instruction opcode, destination register number and six reason flags), and a formatted address (a page-table base ORed with the page number shifted left by three). It records them only while the capture set is unlocked. A capture locks the set, and a read strobe on the address register unlocks it. Software handling the first fault therefore sees that fault's information, and later faults do not overwrite it.

Top module: `dtx_unit`

## Requirements
- R1: After reset, rsp_vld is 0, cap_va, cap_stat and cap_fmt are 0, and cap_locked is 0.
- R2: A request with req_vld high produces rsp_vld high on the next clock edge only. A cycle without a request produces rsp_vld low on the next edge.
- R3: Permission checks index the entry's enable vectors by an effective mode (0 kernel, 1 executive, 2 supervisor, 3 user). When pal_pc is low the effective mode is cur_mode. When pal_pc is high it is alt_mode if req_alt is high, and kernel (0) otherwise.
- R4: A virtual address whose bits 63..42 are not all equal faults with code 2. Its flags are bad-VA and access-violation, plus write on stores. The table response is ignored.
- R5: When sp_ctl[1] is 1 and va[42:41] is 2'b10 (superpage), the access faults with code 1 and flags access-violation (plus write on stores) if cur_mode is not kernel. In kernel mode it completes with pa = va[39:0] zero-extended, and the table response is ignored.
- R6: A table miss on a mapped access faults with the miss flag (plus write on stores). The code is 4 when req_vpte is high and 3 otherwise.
- R7: On a store hit, a clear write-enable bit for the effective mode faults with code 2 and flags write and access-violation, plus fault-on-write if the entry has it set. Otherwise a set fault-on-write bit faults with code 2 and flags write and fault-on-write.
- R8: On a load hit, a clear read-enable bit for the effective mode faults with code 1 and flag access-violation, plus fault-on-read if the entry has it set. Otherwise a set fault-on-read bit faults with code 2 and flag fault-on-read.
- R9: A successful hit returns pa = {tlb_pfn, va[12:0]}, and rsp_uncached equals pa[43]. A faulting response returns pa = 0 and rsp_uncached = 0. A success is code 0.
- R10: A capture loads cap_va with the address and cap_fmt with pt_base | (va[42:13] << 3). It loads cap_stat with {opcode[5:0], ra[4:0], flags[5:0]}, where flag bit 0 is write, 1 access-violation, 2 miss, 3 bad-VA, 4 fault-on-read and 5 fault-on-write.
- R11: A faulting request captures only when cap_locked is 0, and the capture sets cap_locked. va_rd clears cap_locked. A fault that arrives while locked leaves all three registers unchanged, including when va_rd arrives in the same cycle.
- R12: lk_vpn equals va[42:13] and lk_asn equals asn_in, combinationally in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request present |
| req_va | input | 64 | Virtual address |
| req_wr | input | 1 | Store (1) or load (0) |
| req_alt | input | 1 | Use alternate mode when in privileged code |
| req_vpte | input | 1 | Access is a page-table fetch |
| pal_pc | input | 1 | Core is executing privileged code |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| sp_ctl | input | 2 | Superpage enable field |
| asn_in | input | 8 | Address-space number |
| ins_op | input | 6 | Opcode of faulting instruction |
| ins_ra | input | 5 | Register number of faulting instruction |
| pt_base | input | 64 | Base for formatted address |
| va_rd | input | 1 | Address-register read strobe (unlocks) |
| lk_vpn | output | 30 | Page number to the table |
| lk_asn | output | 8 | Address-space number to the table |
| tlb_hit | input | 1 | Table hit |
| tlb_pfn | input | 31 | Frame number |
| tlb_rd_en | input | 4 | Read enables, one per mode |
| tlb_wr_en | input | 4 | Write enables, one per mode |
| tlb_fonr | input | 1 | Fault-on-read |
| tlb_fonw | input | 1 | Fault-on-write |
| rsp_vld | output | 1 | Response valid |
| rsp_pa | output | 44 | Physical address |
| rsp_fault | output | 3 | Fault code |
| rsp_uncached | output | 1 | Uncached access |
| cap_va | output | 64 | Captured faulting address |
| cap_stat | output | 17 | Captured status word |
| cap_fmt | output | 64 | Captured formatted address |
| cap_locked | output | 1 | Capture set locked |

## Verification
The response and all three capture registers pass through exactly one register, so every result of a request is due at the clock edge that ends the request cycle. The lock changes at that same edge. The bench drives inputs at the falling edge and pushes one expected item per cycle. It samples two time units after the next rising edge, so each item is compared against the edge that its own cycle produced. The table lookup outputs are combinational, and the bench checks them one time unit after it drives the address, before any edge.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  typedef enum logic [1:0] {
    MD_KERN = 2'd0,
    MD_EXEC = 2'd1,
    MD_SUPV = 2'd2,
    MD_USER = 2'd3
  } dtx_mode_e;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_ACV   = 3'd1,
    FC_FAULT = 3'd2,
    FC_MISS  = 3'd3,
    FC_DMISS = 3'd4
  } dtx_fault_e;

  localparam int FL_W     = 6;
  localparam int FL_WR    = 0;
  localparam int FL_ACV   = 1;
  localparam int FL_MISS  = 2;
  localparam int FL_BADVA = 3;
  localparam int FL_FONR  = 4;
  localparam int FL_FONW  = 5;

  localparam int OP_W   = 6;
  localparam int RA_W   = 5;
  localparam int STAT_W = OP_W + RA_W + FL_W;

  // Privileged code picks alternate or kernel; otherwise current mode.
  function automatic logic [1:0] pick_mode(input logic pal, input logic use_alt,
                                           input logic [1:0] am, input logic [1:0] cm);
    if (!pal) return cm;
    return use_alt ? am : MD_KERN;
  endfunction

  // Status word: opcode above register number above reason flags.
  function automatic logic [STAT_W-1:0] pack_status(input logic [OP_W-1:0] op,
                                                    input logic [RA_W-1:0] ra,
                                                    input logic [FL_W-1:0] fl);
    return {op, ra, fl};
  endfunction

endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel (
  input  logic       pal_pc,
  input  logic       use_alt,
  input  logic [1:0] alt_mode,
  input  logic [1:0] cur_mode,
  output logic [1:0] eff_mode
);
  import dtx_pkg::*;

  always_comb eff_mode = pick_mode(pal_pc, use_alt, alt_mode, cur_mode);

endmodule

// File: rtl/dtx_classify.sv
module dtx_classify #(
  parameter int VA_W    = 64,
  parameter int IMPL_W  = 43,
  parameter int PA_W    = 44,
  parameter int PG_W    = 13,
  parameter int SP_PA_W = 40,
  localparam int PFN_W  = PA_W - PG_W
) (
  input  logic [VA_W-1:0]     va,
  input  logic                is_wr,
  input  logic                vpte,
  input  logic [1:0]          cur_mode,
  input  logic [1:0]          eff_mode,
  input  logic [1:0]          sp_ctl,
  input  logic                tlb_hit,
  input  logic [PFN_W-1:0]    tlb_pfn,
  input  logic [3:0]          tlb_rd_en,
  input  logic [3:0]          tlb_wr_en,
  input  logic                tlb_fonr,
  input  logic                tlb_fonw,
  output logic [2:0]          fcode,
  output logic [dtx_pkg::FL_W-1:0] flags,
  output logic [PA_W-1:0]     pa,
  output logic                uncached,
  output logic                ev_badva,
  output logic                ev_super,
  output logic                ev_miss
);
  import dtx_pkg::*;

  logic [VA_W-IMPL_W:0] hi_bits;
  logic                 perm_ok;
  logic                 fo_bit;
  logic [PA_W-1:0]      hit_pa;

  assign hi_bits  = va[VA_W-1:IMPL_W-1];
  assign ev_badva = !((&hi_bits) || !(|hi_bits));
  assign ev_super = sp_ctl[1] && (va[IMPL_W-1:IMPL_W-2] == 2'b10);
  assign ev_miss  = !ev_badva && !ev_super && !tlb_hit;
  assign perm_ok  = is_wr ? tlb_wr_en[eff_mode] : tlb_rd_en[eff_mode];
  assign fo_bit   = is_wr ? tlb_fonw : tlb_fonr;
  assign hit_pa   = {tlb_pfn, va[PG_W-1:0]};

  always_comb begin
    fcode = FC_NONE;
    flags = '0;
    pa    = '0;
    flags[FL_WR] = is_wr;
    if (ev_badva) begin
      fcode = FC_FAULT;
      flags[FL_BADVA] = 1'b1;
      flags[FL_ACV]   = 1'b1;
    end else if (ev_super) begin
      if (cur_mode != MD_KERN) begin
        fcode = FC_ACV;
        flags[FL_ACV] = 1'b1;
      end else begin
        pa = PA_W'(va[SP_PA_W-1:0]);
      end
    end else if (!tlb_hit) begin
      fcode = vpte ? FC_DMISS : FC_MISS;
      flags[FL_MISS] = 1'b1;
    end else if (!perm_ok) begin
      fcode = is_wr ? FC_FAULT : FC_ACV;
      flags[FL_ACV] = 1'b1;
      flags[is_wr ? FL_FONW : FL_FONR] = fo_bit;
    end else if (fo_bit) begin
      fcode = FC_FAULT;
      flags[is_wr ? FL_FONW : FL_FONR] = 1'b1;
    end else begin
      pa = hit_pa;
    end
    if (fcode == FC_NONE) flags = '0;
  end

  assign uncached = (fcode == FC_NONE) && pa[PA_W-1];

endmodule

// File: rtl/dtx_capture.sv
module dtx_capture #(
  parameter int VA_W   = 64,
  parameter int STAT_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_ev,
  input  logic              va_rd,
  input  logic [VA_W-1:0]   va_in,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [VA_W-1:0]   fmt_in,
  output logic [VA_W-1:0]   cap_va,
  output logic [STAT_W-1:0] cap_stat,
  output logic [VA_W-1:0]   cap_fmt,
  output logic              locked
);

  logic take;
  assign take = fault_ev && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_va   <= '0;
      cap_stat <= '0;
      cap_fmt  <= '0;
      locked   <= 1'b0;
    end else begin
      if (take) begin
        cap_va   <= va_in;
        cap_stat <= stat_in;
        cap_fmt  <= fmt_in;
      end
      locked <= take || (locked && !va_rd);
    end
  end

  p_hold_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cap_va) && $stable(cap_stat) && $stable(cap_fmt));

  p_lock_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && !locked) |=> locked && (cap_va == $past(va_in)));

  p_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && va_rd) |=> !locked);

endmodule

// File: rtl/dtx_unit.sv
module dtx_unit #(
  parameter int VA_W    = 64,
  parameter int IMPL_W  = 43,
  parameter int PA_W    = 44,
  parameter int PG_W    = 13,
  parameter int SP_PA_W = 40,
  parameter int ASN_W   = 8,
  localparam int VPN_W  = IMPL_W - PG_W,
  localparam int PFN_W  = PA_W - PG_W,
  localparam int STAT_W = dtx_pkg::STAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_wr,
  input  logic               req_alt,
  input  logic               req_vpte,
  input  logic               pal_pc,
  input  logic [1:0]         cur_mode,
  input  logic [1:0]         alt_mode,
  input  logic [1:0]         sp_ctl,
  input  logic [ASN_W-1:0]   asn_in,
  input  logic [5:0]         ins_op,
  input  logic [4:0]         ins_ra,
  input  logic [VA_W-1:0]    pt_base,
  input  logic               va_rd,
  output logic [VPN_W-1:0]   lk_vpn,
  output logic [ASN_W-1:0]   lk_asn,
  input  logic               tlb_hit,
  input  logic [PFN_W-1:0]   tlb_pfn,
  input  logic [3:0]         tlb_rd_en,
  input  logic [3:0]         tlb_wr_en,
  input  logic               tlb_fonr,
  input  logic               tlb_fonw,
  output logic               rsp_vld,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [2:0]         rsp_fault,
  output logic               rsp_uncached,
  output logic [VA_W-1:0]    cap_va,
  output logic [STAT_W-1:0]  cap_stat,
  output logic [VA_W-1:0]    cap_fmt,
  output logic               cap_locked
);
  import dtx_pkg::*;

  logic [1:0]        eff_mode;
  logic [2:0]        d_fcode;
  logic [FL_W-1:0]   d_flags;
  logic [PA_W-1:0]   d_pa;
  logic              d_unc;
  logic              ev_badva, ev_super, ev_miss;
  logic              fault_ev;
  logic [STAT_W-1:0] stat_word;
  logic [VA_W-1:0]   fmt_word;

  assign lk_vpn = req_va[IMPL_W-1:PG_W];
  assign lk_asn = asn_in;

  dtx_mode_sel u_mode (
    .pal_pc   (pal_pc),
    .use_alt  (req_alt),
    .alt_mode (alt_mode),
    .cur_mode (cur_mode),
    .eff_mode (eff_mode)
  );

  dtx_classify #(
    .VA_W(VA_W), .IMPL_W(IMPL_W), .PA_W(PA_W), .PG_W(PG_W), .SP_PA_W(SP_PA_W)
  ) u_cls (
    .va        (req_va),
    .is_wr     (req_wr),
    .vpte      (req_vpte),
    .cur_mode  (cur_mode),
    .eff_mode  (eff_mode),
    .sp_ctl    (sp_ctl),
    .tlb_hit   (tlb_hit),
    .tlb_pfn   (tlb_pfn),
    .tlb_rd_en (tlb_rd_en),
    .tlb_wr_en (tlb_wr_en),
    .tlb_fonr  (tlb_fonr),
    .tlb_fonw  (tlb_fonw),
    .fcode     (d_fcode),
    .flags     (d_flags),
    .pa        (d_pa),
    .uncached  (d_unc),
    .ev_badva  (ev_badva),
    .ev_super  (ev_super),
    .ev_miss   (ev_miss)
  );

  assign fault_ev  = req_vld && (d_fcode != FC_NONE);
  assign stat_word = pack_status(ins_op, ins_ra, d_flags);
  assign fmt_word  = pt_base | (VA_W'(lk_vpn) << 3);

  dtx_capture #(.VA_W(VA_W), .STAT_W(STAT_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_ev (fault_ev),
    .va_rd    (va_rd),
    .va_in    (req_va),
    .stat_in  (stat_word),
    .fmt_in   (fmt_word),
    .cap_va   (cap_va),
    .cap_stat (cap_stat),
    .cap_fmt  (cap_fmt),
    .locked   (cap_locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld      <= 1'b0;
      rsp_pa       <= '0;
      rsp_fault    <= FC_NONE;
      rsp_uncached <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_pa       <= d_pa;
        rsp_fault    <= d_fcode;
        rsp_uncached <= d_unc;
      end
    end
  end

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  p_badva_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ev_badva) |=> (rsp_fault == FC_FAULT));

  p_miss_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ev_miss) |=> (rsp_fault == FC_MISS || rsp_fault == FC_DMISS));

  p_super_kern_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ev_super && !ev_badva && cur_mode == MD_KERN) |=> (rsp_fault == FC_NONE));

  p_fault_zero_pa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_fault != FC_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

endmodule

// File: tb/dtx_unit_bench.sv
module dtx_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, req_alt, req_vpte, pal_pc, va_rd;
  logic [63:0] req_va, pt_base;
  logic [1:0]  cur_mode, alt_mode, sp_ctl;
  logic [7:0]  asn_in;
  logic [5:0]  ins_op;
  logic [4:0]  ins_ra;
  logic [29:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        tlb_hit, tlb_fonr, tlb_fonw;
  logic [30:0] tlb_pfn;
  logic [3:0]  tlb_rd_en, tlb_wr_en;
  logic        rsp_vld, rsp_uncached, cap_locked;
  logic [43:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [63:0] cap_va, cap_fmt;
  logic [16:0] cap_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtx_unit u_dtx_unit (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va), .req_wr(req_wr),
    .req_alt(req_alt), .req_vpte(req_vpte), .pal_pc(pal_pc), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .sp_ctl(sp_ctl), .asn_in(asn_in), .ins_op(ins_op),
    .ins_ra(ins_ra), .pt_base(pt_base), .va_rd(va_rd), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .rsp_vld(rsp_vld), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_uncached(rsp_uncached), .cap_va(cap_va),
    .cap_stat(cap_stat), .cap_fmt(cap_fmt), .cap_locked(cap_locked)
  );

  typedef struct {
    string       tag;
    logic        vld;
    logic [43:0] pa;
    logic [2:0]  fc;
    logic        unc;
    logic [63:0] cva;
    logic [16:0] cstat;
    logic [63:0] cfmt;
    logic        lock;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;

  logic [63:0] m_va, m_fmt;
  logic [16:0] m_stat;
  logic        m_lock;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Independent reference: flags bit0 wr,1 acv,2 miss,3 badva,4 fonr,5 fonw.
  task automatic model(output logic [2:0] fc, output logic [5:0] fl,
                       output logic [43:0] pa, output logic unc);
    logic [1:0] em;
    logic       allowed, fo;
    logic [5:0] w;
    w  = req_wr ? 6'd1 : 6'd0;
    em = pal_pc ? (req_alt ? alt_mode : 2'd0) : cur_mode;
    fc = 3'd0; fl = 6'd0; pa = 44'd0;
    allowed = req_wr ? tlb_wr_en[em] : tlb_rd_en[em];
    fo      = req_wr ? tlb_fonw : tlb_fonr;
    if (req_va[63:42] != 22'h0 && req_va[63:42] != 22'h3FFFFF) begin
      fc = 3'd2; fl = w | 6'd2 | 6'd8;
    end else if (sp_ctl[1] && req_va[42:41] == 2'b10) begin
      if (cur_mode != 2'd0) begin fc = 3'd1; fl = w | 6'd2; end
      else pa = {4'h0, req_va[39:0]};
    end else if (!tlb_hit) begin
      fc = req_vpte ? 3'd4 : 3'd3; fl = w | 6'd4;
    end else if (!allowed) begin
      fc = req_wr ? 3'd2 : 3'd1;
      fl = w | 6'd2 | (fo ? (req_wr ? 6'd32 : 6'd16) : 6'd0);
    end else if (fo) begin
      fc = 3'd2; fl = w | (req_wr ? 6'd32 : 6'd16);
    end else begin
      pa = {tlb_pfn, req_va[12:0]};
    end
    unc = (fc == 3'd0) && pa[43];
  endtask

  // Called at a falling edge with inputs already set; ends at the next falling edge.
  task automatic go(input string tag);
    exp_t e;
    logic [2:0]  fc;
    logic [5:0]  fl;
    logic [43:0] pa;
    logic        unc;
    #1;
    if (req_vld) begin
      chk(lk_vpn == req_va[42:13], "R12", "lk_vpn", 64'(lk_vpn), 64'(req_va[42:13]));
      chk(lk_asn == asn_in, "R12", "lk_asn", 64'(lk_asn), 64'(asn_in));
    end
    model(fc, fl, pa, unc);
    if (req_vld && fc != 3'd0 && !m_lock) begin
      m_va   = req_va;
      m_stat = {ins_op, ins_ra, fl};
      m_fmt  = pt_base | {31'd0, req_va[42:13], 3'd0};
      m_lock = 1'b1;
    end else if (va_rd) begin
      m_lock = 1'b0;
    end
    e.tag = tag; e.vld = req_vld; e.pa = pa; e.fc = fc; e.unc = unc;
    e.cva = m_va; e.cstat = m_stat; e.cfmt = m_fmt; e.lock = m_lock;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(rsp_vld == e.vld, e.tag, "rsp_vld", 64'(rsp_vld), 64'(e.vld));
      if (e.vld) begin
        chk(rsp_fault == e.fc, e.tag, "rsp_fault", 64'(rsp_fault), 64'(e.fc));
        chk(rsp_pa == e.pa, e.tag, "rsp_pa", 64'(rsp_pa), 64'(e.pa));
        chk(rsp_uncached == e.unc, e.tag, "rsp_uncached", 64'(rsp_uncached), 64'(e.unc));
      end
      chk(cap_locked == e.lock, e.tag, "cap_locked", 64'(cap_locked), 64'(e.lock));
      chk(cap_va == e.cva, e.tag, "cap_va", cap_va, e.cva);
      chk(cap_stat == e.cstat, e.tag, "cap_stat", 64'(cap_stat), 64'(e.cstat));
      chk(cap_fmt == e.cfmt, e.tag, "cap_fmt", cap_fmt, e.cfmt);
    end
  end

  task automatic idle();
    req_vld = 1'b0; va_rd = 1'b0;
  endtask

  task automatic load_hit(input logic [63:0] va);
    req_vld = 1'b1; req_wr = 1'b0; req_va = va; req_vpte = 1'b0; va_rd = 1'b0;
    tlb_hit = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 0; req_wr = 0; req_alt = 0; req_vpte = 0; pal_pc = 0; va_rd = 0;
    req_va = '0; pt_base = 64'hFFFF_FFF0_0000_0000; cur_mode = 2'd3; alt_mode = 2'd3;
    sp_ctl = 2'b00; asn_in = 8'h5A; ins_op = 6'h2B; ins_ra = 5'h11;
    tlb_hit = 0; tlb_pfn = '0; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF; tlb_fonr = 0; tlb_fonw = 0;
    m_va = '0; m_stat = '0; m_fmt = '0; m_lock = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_vld == 1'b0, "R1", "rsp_vld", 64'(rsp_vld), 64'd0);
    chk(cap_locked == 1'b0, "R1", "cap_locked", 64'(cap_locked), 64'd0);
    chk(cap_va == 64'd0 && cap_fmt == 64'd0, "R1", "cap_va|fmt", cap_va | cap_fmt, 64'd0);
    chk(cap_stat == 17'd0, "R1", "cap_stat", 64'(cap_stat), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 R2: plain load hit, then uncached frame
    tlb_pfn = 31'h0012_3456; load_hit(64'h0000_0012_3456_7ABC); go("R9_hit");
    tlb_pfn = 31'h4000_0001; load_hit(64'h0000_0000_0000_1FFF); go("R9_uncached");
    idle(); go("R2_idle");

    // R8 R10 R11: read denied with fault-on-read, first capture
    tlb_rd_en = 4'b0111; tlb_fonr = 1; load_hit(64'h0000_0001_2345_6000); go("R8_deny_fonr");
    // R11: store fault while locked does not overwrite
    tlb_rd_en = 4'hF; tlb_fonr = 0; tlb_wr_en = 4'b0111;
    load_hit(64'h0000_0002_0000_0000); req_wr = 1; go("R11_locked_keep");
    idle(); va_rd = 1; go("R11_unlock");
    // R7: write denied without fault-on-write
    ins_op = 6'h0C; ins_ra = 5'h03;
    load_hit(64'hFFFF_FF00_0000_4000); req_wr = 1; go("R7_deny");
    // R11: fault and read together while locked
    load_hit(64'h0000_0003_0000_0000); req_wr = 1; va_rd = 1; go("R11_same_cycle");
    // R7: permitted store with fault-on-write
    tlb_wr_en = 4'hF; tlb_fonw = 1;
    load_hit(64'h0000_0004_5555_0000); req_wr = 1; go("R7_fonw");
    idle(); va_rd = 1; go("R11_unlock2");
    tlb_fonw = 0; tlb_fonr = 1;
    load_hit(64'h0000_0005_0000_2000); go("R8_fonr");
    idle(); va_rd = 1; go("R11_unlock3");
    tlb_fonr = 0;

    // R6: misses
    load_hit(64'h0000_0006_0000_0000); tlb_hit = 0; go("R6_miss");
    idle(); va_rd = 1; go("R6_unlock");
    load_hit(64'h0000_0007_0000_0000); tlb_hit = 0; req_wr = 1; req_vpte = 1; go("R6_dmiss");
    idle(); va_rd = 1; go("R6_unlock2");

    // R4: bad address, table hit ignored
    load_hit(64'h0000_0800_0000_0000); go("R4_badva");
    idle(); va_rd = 1; go("R4_unlock");
    load_hit(64'h8000_0000_0000_0000); req_wr = 1; go("R4_badva_wr");
    idle(); va_rd = 1; go("R4_unlock2");

    // R5: superpage
    sp_ctl = 2'b10; cur_mode = 2'd3;
    load_hit(64'hFFFF_FC12_3456_789A); go("R5_user");
    idle(); va_rd = 1; go("R5_unlock");
    cur_mode = 2'd0; tlb_hit = 0;
    load_hit(64'hFFFF_FC12_3456_789A); tlb_hit = 0; go("R5_kernel");
    sp_ctl = 2'b00; tlb_pfn = 31'h0000_0ABC;
    load_hit(64'hFFFF_FC12_3456_789A); go("R5_disabled");

    // R3: effective mode selection
    tlb_rd_en = 4'b0001; cur_mode = 2'd3; pal_pc = 1; req_alt = 0; alt_mode = 2'd3;
    load_hit(64'h0000_0000_0001_0000); go("R3_pal_kernel");
    req_alt = 1; load_hit(64'h0000_0000_0002_0000); go("R3_pal_alt");
    idle(); va_rd = 1; go("R3_unlock");
    pal_pc = 0; req_alt = 0; cur_mode = 2'd0;
    load_hit(64'h0000_0000_0003_0000); go("R3_current");
    idle(); go("R2_idle2");
    idle(); go("R2_idle3");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule